// File: doc/BRIEF.md
# Ternary Bitwise Lookup Unit

This unit evaluates any Boolean function of three inputs on 64-bit words, the same way a three-input lookup element in programmable logic does. For each bit position, the bits of three operand words form a 3-bit index. That index selects one bit of an 8-bit truth table, and the selected bit becomes the output bit. The truth table comes from one of two places, chosen per operation: an immediate supplied as a 5-bit low field and a 3-bit high field, or the low byte of a fourth operand word.

Two further evaluation styles share the same table. In whole-word mode, each operand is reduced to a single zero/nonzero flag, and one table bit is returned in bit 0 of the result. In swizzle mode, the three low bytes of one operand supply the three inputs. The resulting byte is written into the 8-bit lanes selected by a 4-bit mask, and every other lane keeps the prior destination value. A record flag, when requested, reports a zero result.

Operation requests are captured in an input register and the result is registered. A valid strobe accompanies each result, two clock edges after the request.

Top module: `tlut_unit`

## Requirements
- R1: While reset is asserted, and right after it, `out_valid`, `result` and `zero_flag` are all 0.
- R2: A request sampled with `in_valid` high at one rising edge produces `out_valid` high after the second rising edge that follows. In every other cycle `out_valid` is low, and `result` and `zero_flag` keep their previous values.
- R3: Per-bit mode (`op_mode` = 2'b00): for each bit i, result bit i equals table bit number {t_in[i], a_in[i], b_in[i]}, with t_in as the most significant index bit and b_in as the least significant.
- R4: With `tbl_from_reg` = 0, the table is assembled from the immediate: table bits 4..0 come from `imm_lo[4:0]`, and table bits 7..5 come from `imm_hi[2:0]`.
- R5: With `tbl_from_reg` = 1, the table is `c_in[7:0]`. The immediate fields and `c_in[63:8]` have no effect on the result.
- R6: Whole-word mode (`op_mode` = 2'b01): the index is {t_in≠0, a_in≠0, b_in≠0}, the selected table bit appears in result bit 0, and result bits 63..1 are 0.
- R7: Swizzle mode (`op_mode` = 2'b10): with x = a_in[7:0], y = a_in[15:8] and z = a_in[23:16], lane byte bit k equals table bit {x[k], y[k], z[k]}. Each lane j (result bits 8j+7..8j, j = 0..3) takes that byte when `lane_mask[j]` is 1, and takes the matching t_in byte otherwise. Result bits 63..32 equal t_in[63..32].
- R8: The reserved mode (`op_mode` = 2'b11) yields a result of 0.
- R9: `zero_flag` is 1 with a result exactly when `rec_en` was 1 in the request and the 64-bit result is zero. When `rec_en` was 0, it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op_mode | input | 2 | 00 per-bit, 01 whole-word, 10 swizzle, 11 reserved |
| tbl_from_reg | input | 1 | 1 takes the table from c_in[7:0], 0 from the immediate |
| imm_lo | input | 5 | Immediate table bits 4..0 |
| imm_hi | input | 3 | Immediate table bits 7..5 |
| lane_mask | input | 4 | Swizzle lane write enables |
| rec_en | input | 1 | Request the zero flag |
| t_in | input | 64 | Prior destination value, most significant index input |
| a_in | input | 64 | Middle index input; swizzle source |
| b_in | input | 64 | Least significant index input |
| c_in | input | 64 | Register table source (low byte) |
| out_valid | output | 1 | Result strobe |
| result | output | 64 | Lookup result |
| zero_flag | output | 1 | Zero result indicator when requested |

## Verification
The per-bit path is first driven with byte-periodic operand patterns, in which each byte carries all eight index values. Under these patterns the output reproduces the table in every byte, so the table-bit ordering and the split of the immediate field are exposed directly.

All 256 tables are then swept from both sources against random operands. During the register-sourced sweep, the upper bits of c_in and the immediate are filled with noise, which shows whether anything other than c_in[7:0] leaks into the result.

Whole-word mode is tried with every zero/nonzero combination of the three operands. Swizzle mode is tried with empty, full and alternating lane masks, which separates written lanes from kept lanes.

A table of zero, used with and without the record request, separates the flag logic from the result logic. A random mix of all modes follows.

// File: rtl/tlut_pkg.sv
package tlut_pkg;
    localparam int TBL_BITS = 8;
    localparam int IDX_BITS = 3;

    typedef enum logic [1:0] {
        LUT_PERBIT  = 2'b00,
        LUT_WHOLE   = 2'b01,
        LUT_SWIZZLE = 2'b10,
        LUT_RSVD    = 2'b11
    } lut_mode_e;

    typedef logic [TBL_BITS-1:0] lut_tbl_t;
endpackage

// File: rtl/tlut_table_sel.sv
module tlut_table_sel
    import tlut_pkg::*;
#(
    parameter int LO_W = 5
) (
    input  logic                     from_reg,
    input  logic [LO_W-1:0]          imm_lo,
    input  logic [TBL_BITS-LO_W-1:0] imm_hi,
    input  lut_tbl_t                 reg_tbl,
    output lut_tbl_t                 tbl
);
    // Immediate fields are stitched low-first; the register byte bypasses them.
    always_comb begin
        if (from_reg) tbl = reg_tbl;
        else          tbl = {imm_hi, imm_lo};
    end
endmodule

// File: rtl/tlut_bitwise.sv
module tlut_bitwise
    import tlut_pkg::*;
#(
    parameter int W = 64
) (
    input  lut_tbl_t       tbl,
    input  logic [W-1:0]   t_word,
    input  logic [W-1:0]   a_word,
    input  logic [W-1:0]   b_word,
    output logic [W-1:0]   y
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [IDX_BITS-1:0] idx;
        assign idx  = {t_word[i], a_word[i], b_word[i]};
        assign y[i] = tbl[idx];
    end
endmodule

// File: rtl/tlut_whole.sv
module tlut_whole
    import tlut_pkg::*;
#(
    parameter int W = 64
) (
    input  lut_tbl_t       tbl,
    input  logic [W-1:0]   t_word,
    input  logic [W-1:0]   a_word,
    input  logic [W-1:0]   b_word,
    output logic [W-1:0]   y
);
    logic [IDX_BITS-1:0] idx;

    assign idx = {|t_word, |a_word, |b_word};

    always_comb begin
        y    = '0;
        y[0] = tbl[idx];
    end
endmodule

// File: rtl/tlut_swizzle.sv
module tlut_swizzle
    import tlut_pkg::*;
#(
    parameter int W      = 64,
    parameter int LANE_W = 8,
    parameter int LANES  = 4
) (
    input  lut_tbl_t              tbl,
    input  logic [3*LANE_W-1:0]   src,
    input  logic [W-1:0]          dst_old,
    input  logic [LANES-1:0]      mask,
    output logic [W-1:0]          y
);
    localparam int SPAN = LANES * LANE_W;

    logic [LANE_W-1:0] lane_val;

    for (genvar k = 0; k < LANE_W; k++) begin : g_lane_bit
        logic [IDX_BITS-1:0] idx;
        assign idx         = {src[k], src[LANE_W+k], src[2*LANE_W+k]};
        assign lane_val[k] = tbl[idx];
    end

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign y[j*LANE_W +: LANE_W] = mask[j] ? lane_val
                                               : dst_old[j*LANE_W +: LANE_W];
    end

    if (SPAN < W) begin : g_upper
        assign y[W-1:SPAN] = dst_old[W-1:SPAN];
    end
endmodule

// File: rtl/tlut_unit.sv
module tlut_unit
    import tlut_pkg::*;
#(
    parameter int W      = 64,
    parameter int LANE_W = 8,
    parameter int LANES  = 4,
    parameter int LO_W   = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [1:0]               op_mode,
    input  logic                     tbl_from_reg,
    input  logic [LO_W-1:0]          imm_lo,
    input  logic [TBL_BITS-LO_W-1:0] imm_hi,
    input  logic [LANES-1:0]         lane_mask,
    input  logic                     rec_en,
    input  logic [W-1:0]             t_in,
    input  logic [W-1:0]             a_in,
    input  logic [W-1:0]             b_in,
    input  logic [W-1:0]             c_in,
    output logic                     out_valid,
    output logic [W-1:0]             result,
    output logic                     zero_flag
);
    localparam int HI_W  = TBL_BITS - LO_W;
    localparam int SRC_W = 3 * LANE_W;

    typedef struct packed {
        logic             vld;
        lut_mode_e        mode;
        logic             from_reg;
        logic [LO_W-1:0]  lo;
        logic [HI_W-1:0]  hi;
        logic [LANES-1:0] mask;
        logic             rec;
        logic [W-1:0]     t;
        logic [W-1:0]     a;
        logic [W-1:0]     b;
        lut_tbl_t         c;
    } req_t;

    typedef struct packed {
        logic         vld;
        logic [W-1:0] res;
        logic         zf;
    } rsp_t;

    typedef struct packed {
        req_t req;
        rsp_t rsp;
    } state_t;

    state_t st_d, st_q;

    // Only the table byte of c_in is meaningful.
    logic c_hi_unused;
    assign c_hi_unused = ^c_in[W-1:TBL_BITS];

    lut_tbl_t     tbl;
    logic [W-1:0] bit_res;
    logic [W-1:0] whole_res;
    logic [W-1:0] swz_res;
    logic [W-1:0] res_sel;

    tlut_table_sel #(.LO_W(LO_W)) u_tbl (
        .from_reg (st_q.req.from_reg),
        .imm_lo   (st_q.req.lo),
        .imm_hi   (st_q.req.hi),
        .reg_tbl  (st_q.req.c),
        .tbl      (tbl)
    );

    tlut_bitwise #(.W(W)) u_bit (
        .tbl    (tbl),
        .t_word (st_q.req.t),
        .a_word (st_q.req.a),
        .b_word (st_q.req.b),
        .y      (bit_res)
    );

    tlut_whole #(.W(W)) u_whole (
        .tbl    (tbl),
        .t_word (st_q.req.t),
        .a_word (st_q.req.a),
        .b_word (st_q.req.b),
        .y      (whole_res)
    );

    tlut_swizzle #(.W(W), .LANE_W(LANE_W), .LANES(LANES)) u_swz (
        .tbl     (tbl),
        .src     (st_q.req.a[SRC_W-1:0]),
        .dst_old (st_q.req.t),
        .mask    (st_q.req.mask),
        .y       (swz_res)
    );

    always_comb begin
        unique case (st_q.req.mode)
            LUT_PERBIT:  res_sel = bit_res;
            LUT_WHOLE:   res_sel = whole_res;
            LUT_SWIZZLE: res_sel = swz_res;
            default:     res_sel = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;

        st_d.req.vld = in_valid;
        if (in_valid) begin
            st_d.req.mode     = lut_mode_e'(op_mode);
            st_d.req.from_reg = tbl_from_reg;
            st_d.req.lo       = imm_lo;
            st_d.req.hi       = imm_hi;
            st_d.req.mask     = lane_mask;
            st_d.req.rec      = rec_en;
            st_d.req.t        = t_in;
            st_d.req.a        = a_in;
            st_d.req.b        = b_in;
            st_d.req.c        = c_in[TBL_BITS-1:0];
        end

        st_d.rsp.vld = st_q.req.vld;
        if (st_q.req.vld) begin
            st_d.rsp.res = res_sel;
            st_d.rsp.zf  = st_q.req.rec && (res_sel == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.rsp.vld;
    assign result    = st_q.rsp.res;
    assign zero_flag = st_q.rsp.zf;
endmodule

// File: rtl/tlut_unit_chk.sv
module tlut_unit_chk #(
    parameter int W      = 64,
    parameter int LANE_W = 8,
    parameter int LANES  = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [1:0]   op_mode,
    input logic         rec_en,
    input logic [W-1:0] t_in,
    input logic         out_valid,
    input logic [W-1:0] result,
    input logic         zero_flag
);
    localparam int SPAN = LANES * LANE_W;

    // Edges seen since reset release, saturating; gates $past lookbacks.
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (!rst_n)             age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd1 && !out_valid) |-> ($stable(result) && $stable(zero_flag)));

    p_whole_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && out_valid && $past(op_mode, 2) == 2'b01)
        |-> (result[W-1:1] == '0));

    p_swz_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && out_valid && $past(op_mode, 2) == 2'b10)
        |-> (result[W-1:SPAN] == $past(t_in[W-1:SPAN], 2)));

    p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && out_valid && $past(op_mode, 2) == 2'b11)
        |-> (result == '0));

    p_flag_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        zero_flag |-> (result == '0));

    p_flag_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && out_valid && !$past(rec_en, 2)) |-> !zero_flag);
endmodule

bind tlut_unit tlut_unit_chk #(.W(W), .LANE_W(LANE_W), .LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_mode   (op_mode),
    .rec_en    (rec_en),
    .t_in      (t_in),
    .out_valid (out_valid),
    .result    (result),
    .zero_flag (zero_flag)
);

// File: tb/sim_tlut_unit.sv
module sim_tlut_unit;
    localparam int W      = 64;
    localparam int LANE_W = 8;
    localparam int LANES  = 4;
    localparam int LO_W   = 5;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [1:0]   op_mode;
    logic         tbl_from_reg;
    logic [4:0]   imm_lo;
    logic [2:0]   imm_hi;
    logic [3:0]   lane_mask;
    logic         rec_en;
    logic [W-1:0] t_in, a_in, b_in, c_in;
    logic         out_valid;
    logic [W-1:0] result;
    logic         zero_flag;

    int n_chk  = 0;
    int n_fail = 0;
    logic [W-1:0] last_res;
    logic         last_zf;

    always #4 clk = ~clk;

    tlut_unit #(.W(W), .LANE_W(LANE_W), .LANES(LANES), .LO_W(LO_W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_mode(op_mode),
        .tbl_from_reg(tbl_from_reg), .imm_lo(imm_lo), .imm_hi(imm_hi),
        .lane_mask(lane_mask), .rec_en(rec_en), .t_in(t_in), .a_in(a_in),
        .b_in(b_in), .c_in(c_in), .out_valid(out_valid), .result(result),
        .zero_flag(zero_flag)
    );

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    function automatic logic [W-1:0] model(logic [1:0] mode, logic sel,
            logic [4:0] lo, logic [2:0] hi, logic [3:0] msk,
            logic [W-1:0] t, logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
        logic [7:0]   tb;
        logic [W-1:0] r;
        tb = sel ? c[7:0] : {hi, lo};
        r  = '0;
        case (mode)
            2'b00: for (int i = 0; i < W; i++) r[i] = tb[{t[i], a[i], b[i]}];
            2'b01: r[0] = tb[{|t, |a, |b}];
            2'b10: begin
                r = t;
                for (int k = 0; k < 8; k++)
                    for (int j = 0; j < 4; j++)
                        if (msk[j]) r[j*8+k] = tb[{a[k], a[8+k], a[16+k]}];
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic run_op(string req, logic [1:0] mode, logic sel,
            logic [4:0] lo, logic [2:0] hi, logic [3:0] msk, logic rec,
            logic [W-1:0] t, logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
        logic [W-1:0] exp;
        logic         ezf;
        exp = model(mode, sel, lo, hi, msk, t, a, b, c);
        ezf = rec && (exp == '0);
        op_mode = mode; tbl_from_reg = sel; imm_lo = lo; imm_hi = hi;
        lane_mask = msk; rec_en = rec; t_in = t; a_in = a; b_in = b; c_in = c;
        in_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        check("R2 valid too early", {63'b0, out_valid}, 64'd0);
        check("R2 result held", result, last_res);
        @(posedge clk); @(negedge clk);
        check("R2 valid after two edges", {63'b0, out_valid}, 64'd1);
        check(req, result, exp);
        check("R9 zero flag", {63'b0, zero_flag}, {63'b0, ezf});
        last_res = exp;
        last_zf  = ezf;
    endtask

    function automatic logic [W-1:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R2: actual hung expected completion");
        report();
    end

    initial begin
        void'($urandom(32'd7321));
        rst_n = 1'b0; in_valid = 1'b0; op_mode = '0; tbl_from_reg = 1'b0;
        imm_lo = '0; imm_hi = '0; lane_mask = '0; rec_en = 1'b0;
        t_in = '0; a_in = '0; b_in = '0; c_in = '0;
        repeat (4) @(negedge clk);
        check("R1 reset out_valid", {63'b0, out_valid}, 64'd0);
        check("R1 reset result", result, 64'd0);
        check("R1 reset zero_flag", {63'b0, zero_flag}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset result", result, 64'd0);
        last_res = '0;
        last_zf  = 1'b0;

        // R3 / R4: byte-periodic operands hit all eight indices in every byte
        run_op("R3 majority table", 2'b00, 1'b0, 5'b01000, 3'b111, 4'h0, 1'b0,
               {8{8'hF0}}, {8{8'hCC}}, {8{8'hAA}}, rnd64());
        run_op("R4 low field only", 2'b00, 1'b0, 5'h1F, 3'h0, 4'h0, 1'b0,
               {8{8'hF0}}, {8{8'hCC}}, {8{8'hAA}}, rnd64());
        run_op("R4 high field only", 2'b00, 1'b0, 5'h00, 3'h7, 4'h0, 1'b0,
               {8{8'hF0}}, {8{8'hCC}}, {8{8'hAA}}, rnd64());
        run_op("R4 single bit five", 2'b00, 1'b0, 5'h00, 3'h1, 4'h0, 1'b0,
               {8{8'hF0}}, {8{8'hCC}}, {8{8'hAA}}, rnd64());

        // R5: register table, upper c_in bits and immediate are noise
        run_op("R5 register table", 2'b00, 1'b1, 5'h15, 3'h2, 4'h0, 1'b0,
               {8{8'hF0}}, {8{8'hCC}}, {8{8'hAA}}, {56'hDEAD_BEEF_0123_45, 8'h96});
        run_op("R5 upper c bits ignored", 2'b00, 1'b1, 5'h0A, 3'h5, 4'h0, 1'b0,
               {8{8'hF0}}, {8{8'hCC}}, {8{8'hAA}}, {56'h0, 8'h96});

        // R6: every zero/nonzero combination
        for (int m = 0; m < 8; m++) begin
            run_op("R6 whole-word", 2'b01, 1'b0, 5'b10100, 3'b101, 4'h0, 1'b0,
                   m[2] ? (rnd64() | 64'h1) : 64'h0,
                   m[1] ? (64'h1 << ($urandom() % 64)) : 64'h0,
                   m[0] ? (rnd64() | 64'h8000_0000_0000_0000) : 64'h0,
                   rnd64());
        end

        // R7: lane masks
        run_op("R7 swizzle mask 0", 2'b10, 1'b0, 5'h16, 3'h3, 4'h0, 1'b0,
               rnd64(), rnd64(), rnd64(), rnd64());
        run_op("R7 swizzle mask F", 2'b10, 1'b0, 5'h16, 3'h3, 4'hF, 1'b0,
               rnd64(), rnd64(), rnd64(), rnd64());
        run_op("R7 swizzle mask 5", 2'b10, 1'b1, 5'h00, 3'h0, 4'h5, 1'b0,
               rnd64(), {40'h0, 8'hF0, 8'hCC, 8'hAA}, rnd64(), {56'h0, 8'h6B});
        run_op("R7 swizzle mask A", 2'b10, 1'b0, 5'h0D, 3'h6, 4'hA, 1'b0,
               rnd64(), rnd64(), rnd64(), rnd64());

        // R8
        run_op("R8 reserved mode", 2'b11, 1'b0, 5'h1F, 3'h7, 4'hF, 1'b0,
               rnd64(), rnd64(), rnd64(), rnd64());

        // R9
        run_op("R9 zero with record", 2'b00, 1'b0, 5'h00, 3'h0, 4'h0, 1'b1,
               rnd64(), rnd64(), rnd64(), rnd64());
        run_op("R9 zero without record", 2'b00, 1'b0, 5'h00, 3'h0, 4'h0, 1'b0,
               rnd64(), rnd64(), rnd64(), rnd64());
        run_op("R9 nonzero with record", 2'b00, 1'b0, 5'h1F, 3'h7, 4'h0, 1'b1,
               rnd64(), rnd64(), rnd64(), rnd64());

        // R3 / R4 / R5: full table sweep from both sources
        for (int tv = 0; tv < 256; tv++) begin
            logic [7:0] tb8;
            tb8 = tv[7:0];
            run_op("R4 immediate sweep", 2'b00, 1'b0, tb8[4:0], tb8[7:5], 4'h0,
                   1'b1, rnd64(), rnd64(), rnd64(), rnd64());
            run_op("R5 register sweep", 2'b00, 1'b1, 5'($urandom()), 3'($urandom()),
                   4'h0, 1'b1, rnd64(), rnd64(), rnd64(), {rnd64() & ~64'hFF} | {56'h0, tb8});
        end

        // Random mix of all modes (R3 R6 R7 R8 R9)
        for (int n = 0; n < 300; n++) begin
            logic [1:0] md;
            md = 2'($urandom());
            run_op("R3 random mixed mode", md, 1'($urandom()), 5'($urandom()),
                   3'($urandom()), 4'($urandom()), 1'($urandom()),
                   ($urandom() % 4 == 0) ? 64'h0 : rnd64(),
                   ($urandom() % 4 == 0) ? 64'h0 : rnd64(),
                   ($urandom() % 4 == 0) ? 64'h0 : rnd64(),
                   rnd64());
        end

        repeat (2) @(negedge clk);
        check("R2 idle valid low", {63'b0, out_valid}, 64'd0);
        check("R2 idle result held", result, last_res);
        check("R2 idle flag held", {63'b0, zero_flag}, {63'b0, last_zf});
        report();
    end
endmodule